// File: doc/BRIEF.md
# Test Pin Selector with Divider-Chain Bypass

This block chooses which of eight internal signals appears on a single test pin of a clock synthesizer. A 3-bit select code picks a serial shift-register output, constant high or low, the reference clock, the loop M counter output, the synthesized output clock, or a divide-by-4 copy of that output clock. The loop M counter is part of the block. A 2-bit counter that advances on each rising edge of the output clock produces the divide-by-4 tap.

One select code puts the block into bypass. In bypass the serial clock, not the VCO-rate clock, advances the loop M counter. The block raises a clock-source select output that tells the output divider to take the serial clock as well. The M counter pulse goes to the test pin, so slow board-level debug clocks can be traced through the divider chain.

All clocks are modelled as level signals or edge strobes sampled by one system clock. Each clock source is therefore an enable on the same flops. The M counter reloads from the M input at terminal count and gives a one-cycle pulse. It does not give a 50% duty cycle.

Top module: `testpin_selector`

## Requirements
- R1: Select code 3'b000 drives the shift-register output onto the test pin.
- R2: Select code 3'b001 drives the test pin high, and code 3'b101 drives it low, whatever the other inputs do.
- R3: Select code 3'b010 drives the reference clock level onto the test pin.
- R4: Select code 3'b011 drives the M counter pulse onto the test pin, while the VCO-rate strobe advances the counter.
- R5: Select code 3'b100 drives the synthesized output clock level onto the test pin.
- R6: Select code 3'b111 drives bit 1 of a 2-bit counter onto the test pin. The counter starts at 0 after reset and adds one on each rising edge of the output clock.
- R7: Select code 3'b110 is bypass. The clock-source select output is 1, the serial clock strobe advances the M counter, and the M counter pulse drives the test pin.
- R8: When the clock-source select is 0, only the VCO-rate strobe advances the M counter and the serial strobe has no effect. When it is 1, only the serial strobe advances the counter.
- R9: The M counter pulses on the first advance after reset. It then pulses once every M advances, holding the pulse for one cycle. An M of 0 or 1 pulses on every advance.
- R10: The clock-source select is registered. It equals (select code == 3'b110) of the previous cycle, it is 0 in reset, and it changes only when the select code has changed.
- R11: The test pin is registered. It shows the selected source as sampled in the previous cycle and is 0 in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock sampling all clock levels and strobes |
| rst | input | 1 | Synchronous active-high reset |
| test_sel | input | 3 | Test select code |
| ref_lvl | input | 1 | Reference clock level |
| vco_stb | input | 1 | VCO-rate clock edge strobe |
| sclk_stb | input | 1 | Serial clock edge strobe |
| sr_out | input | 1 | Serial shift-register output |
| fout_lvl | input | 1 | Output divider result (synthesized clock level) |
| m_val | input | 7 | Loop divider modulus M |
| test_pin | output | 1 | Test pin |
| clk_src_sel | output | 1 | 1 selects the serial clock as divider-chain source |

## Verification
The bench switches codes in and out of bypass while both strobes toggle at random. A design that registered the source select late or not at all would advance the M counter from the wrong strobe, and the pulse train on the pin would drift. Small modulus values 0, 1 and 2 test reload at terminal count: an off-by-one reload lengthens or shortens the pulse period. The divide-by-4 tap runs while the output clock level stays high for several cycles, which exposes a counter that counts levels instead of rising edges.

// File: rtl/testpin_pkg.sv
package testpin_pkg;

    typedef enum logic [2:0] {
        TS_SHIFT   = 3'b000,
        TS_HIGH    = 3'b001,
        TS_REF     = 3'b010,
        TS_MCNT    = 3'b011,
        TS_FOUT    = 3'b100,
        TS_LOW     = 3'b101,
        TS_BYPASS  = 3'b110,
        TS_QUARTER = 3'b111
    } tsel_e;

    typedef struct packed {
        logic sr;
        logic ref_clk;
        logic mpulse;
        logic fout;
        logic quarter;
    } tap_src_t;

    function automatic logic is_bypass(input logic [2:0] code);
        return code == TS_BYPASS;
    endfunction

    function automatic logic pick_tap(input logic [2:0] code, input tap_src_t s);
        logic r;
        case (tsel_e'(code))
            TS_SHIFT:   r = s.sr;
            TS_HIGH:    r = 1'b1;
            TS_REF:     r = s.ref_clk;
            TS_MCNT:    r = s.mpulse;
            TS_FOUT:    r = s.fout;
            TS_LOW:     r = 1'b0;
            TS_BYPASS:  r = s.mpulse;
            default:    r = s.quarter;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/testpin_mcount.sv
module testpin_mcount #(
    parameter int M_W = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           adv,
    input  logic [M_W-1:0] m_val,
    output logic           pulse
);
    logic [M_W-1:0] cnt;
    logic [M_W-1:0] reload;

    always_comb begin
        reload = (m_val == '0) ? '0 : m_val - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (adv) begin
            if (cnt == '0) begin
                cnt   <= reload;
                pulse <= 1'b1;
            end else begin
                cnt   <= cnt - 1'b1;
                pulse <= 1'b0;
            end
        end else begin
            pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/testpin_quarter.sv
module testpin_quarter #(
    parameter int Q_W = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           fout_lvl,
    output logic           rise,
    output logic [Q_W-1:0] q
);
    logic fout_d;

    assign rise = fout_lvl & ~fout_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            fout_d <= 1'b0;
            q      <= '0;
        end else begin
            fout_d <= fout_lvl;
            if (rise) q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/testpin_selector.sv
module testpin_selector
    import testpin_pkg::*;
#(
    parameter int M_W = 7,
    parameter int Q_W = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2:0]     test_sel,
    input  logic           ref_lvl,
    input  logic           vco_stb,
    input  logic           sclk_stb,
    input  logic           sr_out,
    input  logic           fout_lvl,
    input  logic [M_W-1:0] m_val,
    output logic           test_pin,
    output logic           clk_src_sel
);
    localparam int TAP_BIT = Q_W - 1;

    logic           m_adv;
    logic           m_pulse;
    logic           fout_rise;
    logic [Q_W-1:0] div_q;
    tap_src_t       src;

    always_ff @(posedge clk) begin
        if (rst) clk_src_sel <= 1'b0;
        else     clk_src_sel <= is_bypass(test_sel);
    end

    assign m_adv = clk_src_sel ? sclk_stb : vco_stb;

    testpin_mcount #(.M_W(M_W)) u_mcnt (
        .clk   (clk),
        .rst   (rst),
        .adv   (m_adv),
        .m_val (m_val),
        .pulse (m_pulse)
    );

    testpin_quarter #(.Q_W(Q_W)) u_quarter (
        .clk      (clk),
        .rst      (rst),
        .fout_lvl (fout_lvl),
        .rise     (fout_rise),
        .q        (div_q)
    );

    always_comb begin
        src.sr      = sr_out;
        src.ref_clk = ref_lvl;
        src.mpulse  = m_pulse;
        src.fout    = fout_lvl;
        src.quarter = div_q[TAP_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) test_pin <= 1'b0;
        else     test_pin <= pick_tap(test_sel, src);
    end
endmodule

// File: rtl/testpin_selector_chk.sv
module testpin_selector_chk #(
    parameter int Q_W = 2
) (
    input logic           clk,
    input logic           rst,
    input logic [2:0]     test_sel,
    input logic           test_pin,
    input logic           clk_src_sel,
    input logic           fout_rise,
    input logic [Q_W-1:0] div_q
);
    AST_CONST_HIGH: assert property (@(posedge clk) disable iff (rst)
        (test_sel == 3'b001) |=> test_pin);                       // R2
    AST_CONST_LOW: assert property (@(posedge clk) disable iff (rst)
        (test_sel == 3'b101) |=> !test_pin);                      // R2
    AST_BYPASS_SEL: assert property (@(posedge clk) disable iff (rst)
        (test_sel == 3'b110) |=> clk_src_sel);                    // R7
    AST_SEL_OFF: assert property (@(posedge clk) disable iff (rst)
        (test_sel != 3'b110) |=> !clk_src_sel);                   // R10
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($stable(test_sel) && clk_src_sel == (test_sel == 3'b110)) |=> $stable(clk_src_sel)); // R10
    AST_QUARTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fout_rise |=> $stable(div_q));                           // R6
endmodule

bind testpin_selector testpin_selector_chk #(.Q_W(Q_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .test_sel    (test_sel),
    .test_pin    (test_pin),
    .clk_src_sel (clk_src_sel),
    .fout_rise   (fout_rise),
    .div_q       (div_q)
);

// File: tb/testpin_selector_test.sv
module testpin_selector_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] test_sel = 3'b000;
    logic       ref_lvl = 1'b0, vco_stb = 1'b0, sclk_stb = 1'b0;
    logic       sr_out = 1'b0, fout_lvl = 1'b0;
    logic [6:0] m_val = 7'd5;
    logic       test_pin, clk_src_sel;

    int n_cmp = 0, n_bad = 0;

    // reference model state
    logic       e_sel, e_pulse, e_foutd, e_pin;
    logic [6:0] e_cnt;
    logic [1:0] e_div;
    int         pulses;

    always #10 clk = ~clk;

    testpin_selector uut (
        .clk(clk), .rst(rst), .test_sel(test_sel), .ref_lvl(ref_lvl),
        .vco_stb(vco_stb), .sclk_stb(sclk_stb), .sr_out(sr_out),
        .fout_lvl(fout_lvl), .m_val(m_val), .test_pin(test_pin),
        .clk_src_sel(clk_src_sel)
    );

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd0: return "R1";
            3'd1, 3'd5: return "R2";
            3'd2: return "R3";
            3'd3: return "R4/R9";
            3'd4: return "R5";
            3'd6: return "R7/R8";
            default: return "R6";
        endcase
    endfunction

    function automatic logic exp_pin(input logic [2:0] c, input logic pl, input logic [1:0] dv);
        case (c)
            3'd0: return sr_out;
            3'd1: return 1'b1;
            3'd2: return ref_lvl;
            3'd3, 3'd6: return pl;
            3'd4: return fout_lvl;
            3'd5: return 1'b0;
            default: return dv[1];
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        e_sel = 0; e_pulse = 0; e_foutd = 0; e_pin = 0; e_cnt = 0; e_div = 0;
    endtask

    // one cycle: inputs already driven; advance model and DUT, then compare
    task automatic step();
        logic adv, n_pulse, n_pin;
        logic [6:0] n_cnt;
        logic [1:0] n_div;
        adv = e_sel ? sclk_stb : vco_stb;          // R8
        n_cnt = e_cnt; n_pulse = 1'b0;
        if (adv) begin
            if (e_cnt == 0) begin                   // R9
                n_cnt = (m_val == 0) ? 7'd0 : m_val - 7'd1;
                n_pulse = 1'b1;
            end else n_cnt = e_cnt - 7'd1;
        end
        n_div = (fout_lvl && !e_foutd) ? e_div + 2'd1 : e_div;
        n_pin = exp_pin(test_sel, e_pulse, e_div);
        @(posedge clk);
        #5;
        e_sel = (test_sel == 3'd6); e_cnt = n_cnt; e_pulse = n_pulse;
        e_div = n_div; e_foutd = fout_lvl; e_pin = n_pin;
        check(req_of(test_sel), test_pin, e_pin);    // R11
        check("R10", clk_src_sel, e_sel);
        if (test_pin) pulses++;
        @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        // reset state, with inputs that would otherwise set outputs
        test_sel = 3'd6; sclk_stb = 1; vco_stb = 1;
        @(posedge clk); #5;
        check("R11", test_pin, 1'b0);
        check("R10", clk_src_sel, 1'b0);
        @(negedge clk);
        rst = 0; test_sel = 3'd0; sclk_stb = 0; vco_stb = 0;

        // R2 constants under toggling inputs
        test_sel = 3'd1;
        for (int i = 0; i < 6; i++) begin
            sr_out = i[0]; ref_lvl = ~i[0]; fout_lvl = i[1]; step();
        end
        test_sel = 3'd5;
        for (int i = 0; i < 6; i++) begin
            sr_out = i[0]; ref_lvl = ~i[0]; fout_lvl = i[1]; step();
        end

        // R7/R9: bypass with M=3, serial strobe every cycle, VCO idle -> pulse every 3
        test_sel = 3'd6; m_val = 7'd3; vco_stb = 0; sclk_stb = 1;
        step();                                     // select settles
        pulses = 0;
        for (int i = 0; i < 12; i++) step();
        check("R7", logic'(pulses == 4), 1'b1);

        // R8: in bypass, VCO strobes ignored -> no pulses
        sclk_stb = 0; vco_stb = 1;
        step(); step();
        pulses = 0;
        for (int i = 0; i < 10; i++) step();
        check("R8", logic'(pulses == 0), 1'b1);

        // R4/R8: code 011, serial strobe ignored, VCO advances
        test_sel = 3'd3; vco_stb = 0; sclk_stb = 1;
        step(); step();
        for (int i = 0; i < 8; i++) step();
        // R9: M=0 and M=1 pulse on every advance
        vco_stb = 1; sclk_stb = 0; m_val = 7'd1;
        for (int i = 0; i < 6; i++) step();
        m_val = 7'd0;
        for (int i = 0; i < 6; i++) step();
        m_val = 7'd2;
        for (int i = 0; i < 8; i++) step();

        // R6: fout held high several cycles, then toggled
        test_sel = 3'd7;
        for (int i = 0; i < 24; i++) begin
            fout_lvl = (i % 6) < 3; step();
        end

        // random mix covering R1, R3, R5 and all codes
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 7) == 0) test_sel = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 31) == 0) m_val = 7'($urandom_range(0, 6));
            ref_lvl  = 1'($urandom);
            vco_stb  = 1'($urandom);
            sclk_stb = 1'($urandom);
            sr_out   = 1'($urandom);
            fout_lvl = 1'($urandom);
            step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule